// File: doc/BRIEF.md
# Nine-Clock Synchronous Serial Slave

This block is a slave-only synchronous serial port. An external master drives a serial clock, a data line into the block and an active-low select. The block returns data on an output line that it drives only while select is low. Each exchange is a frame of nine serial clock pulses, and data moves in both directions at once, least significant bit first. The block keeps the first eight incoming bits of a frame and drops the ninth. It sends eight data bits and then a ninth bit that is always 1.

All three serial inputs pass through two-flop synchronizers into the system clock domain, and serial clock edges are found by comparing successive synchronized samples. Frames use nine pulses from the start, including before any mode is chosen. The first two complete frames are initialization bytes. The pair 0x00 then 0xFF switches the block into the nine-clock data mode. Any other pair leaves it outside that mode until reset. The outcome appears on two plain status pins.

On the system side, received bytes leave on a valid/ready stream. The serial master cannot be stalled, so this stream applies no back-pressure: a byte waits with valid high until ready is seen, and a newer byte replaces it if it was not taken in time. Bytes to transmit enter through a one-entry valid/ready buffer. Ready is low while a byte is waiting, and the byte is taken when the next frame starts.

Top module: `ninec_serial_slave`

## Requirements
- R1: After reset, rx_valid_o is 0, tx_ready_o is 1, and mode_done_o and mode_ok_o are both 0.
- R2: A frame is nine rising serial clock edges while select is low. Each complete frame yields exactly one received byte, which appears within a few system clocks after the ninth rising edge.
- R3: Input bits are sampled on rising serial clock edges. The first bit of a frame goes to byte bit 0 and the eighth to bit 7, and the ninth input bit has no effect on the byte.
- R4: Output bit k of the loaded byte (LSB first) is valid on sdo_o before the (k+1)-th rising edge of the frame, with bit 0 presented after select falls. The ninth output bit is always 1.
- R5: If no byte is waiting in the transmit buffer when a frame starts, the eight data bits sent are all 1 (0xFF).
- R6: Raising select before the ninth rising edge aborts the frame. No byte is reported for it, and the next frame starts again at bit 0.
- R7: Of the first two complete frames, the pair 0x00 then 0xFF sets mode_done_o=1 and mode_ok_o=1. Any other pair sets mode_done_o=1 and mode_ok_o=0, and both stay fixed until reset. Initialization bytes are never delivered. While mode_ok_o=0, no byte is delivered, the output sends all ones, and the transmit buffer is not consumed.
- R8: sdo_en_o is 0 while sel_n_i is high and 1 while it is low (0 means high-impedance).
- R9: rx_valid_o stays high with rx_data_o stable until rx_ready_i is sampled high. A byte that arrives while one is pending replaces it.
- R10: tx_ready_o is high exactly when the transmit buffer is empty. A byte accepted with tx_valid_i is taken at the next frame start, and tx_ready_o then returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| sdi_i | input | 1 | Serial data from master to slave |
| sel_n_i | input | 1 | Active-low slave select |
| sdo_o | output | 1 | Serial data from slave to master |
| sdo_en_o | output | 1 | Output enable for sdo_o; 0 means high-impedance |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Consumer has taken the received byte |
| tx_data_i | input | 8 | Byte to send in a coming frame |
| tx_valid_i | input | 1 | tx_data_i is offered |
| tx_ready_o | output | 1 | Transmit buffer is empty and can accept |
| mode_done_o | output | 1 | The initialization pair has been received |
| mode_ok_o | output | 1 | The pair selected the nine-clock data mode |

## Verification
The assertions assume that the serial clock idles low, and that each serial clock phase lasts long enough for the synchronizers to see every edge. Select must not change in the same system cycle as a serial clock edge, and sdi_i must be stable across each rising edge. The bench keeps each phase at eight system clocks and moves select only while the serial clock is low and quiet. It changes data at the start of the low phase and samples sdo_o at the end of the low phase. Under these conditions, each stated timing bound falls well inside its phase.

// File: rtl/nss_pkg.sv
package nss_pkg;
  typedef enum logic [1:0] {
    MODE_FIRST  = 2'd0,
    MODE_SECOND = 2'd1,
    MODE_ON     = 2'd2,
    MODE_OFF    = 2'd3
  } mode_state_e;
endpackage

// File: rtl/nss_sync.sv
module nss_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/nss_frame_ctl.sv
module nss_frame_ctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              sel_s,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_done_o,
  output logic              load_req_o,
  output logic              shift_req_o
);
  localparam int FRAME = DATA_W + 1;
  localparam int CW    = $clog2(FRAME + 1);

  logic          sclk_q, sel_q, seam;
  logic [CW-1:0] cnt;
  logic          rise, fall, sel_start;

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign sel_start = sel_s & ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= 1'b0;
      sel_q       <= 1'b0;
      seam        <= 1'b0;
      cnt         <= '0;
      rx_byte_o   <= '0;
      rx_done_o   <= 1'b0;
      load_req_o  <= 1'b0;
      shift_req_o <= 1'b0;
    end else begin
      sclk_q      <= sclk_s;
      sel_q       <= sel_s;
      rx_done_o   <= 1'b0;
      load_req_o  <= 1'b0;
      shift_req_o <= 1'b0;
      if (!sel_s) begin
        cnt  <= '0;
        seam <= 1'b0;
      end else begin
        if (sel_start) load_req_o <= 1'b1;
        if (rise) begin
          if (cnt < CW'(DATA_W)) rx_byte_o <= {sdi_s, rx_byte_o[DATA_W-1:1]};
          if (cnt == CW'(FRAME - 1)) begin
            cnt       <= '0;
            rx_done_o <= 1'b1;
            seam      <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end else if (fall) begin
          if (cnt == '0) begin
            if (seam) load_req_o <= 1'b1;
            seam <= 1'b0;
          end else begin
            shift_req_o <= 1'b1;
          end
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME - 1)); // R2
  AST_DONE_AFTER_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_o |-> $past(cnt) == CW'(FRAME - 1)); // R2
  AST_DESELECT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> (cnt == '0) && !rx_done_o); // R6
endmodule

// File: rtl/nss_tx.sv
module nss_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              mode_ok,
  input  logic              load_req,
  input  logic              shift_req,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              sdo_bit_o
);
  localparam int FRAME = DATA_W + 1;

  logic [DATA_W-1:0] hold;
  logic              full;
  logic [FRAME-1:0]  sh;
  logic              take;

  assign take       = load_req & mode_ok & full;
  assign tx_ready_o = ~full;
  assign sdo_bit_o  = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
      sh   <= '1;
    end else begin
      if (!sel_s)          sh <= '1;
      else if (load_req)   sh <= take ? {1'b1, hold} : '1;
      else if (shift_req)  sh <= {1'b1, sh[FRAME-1:1]};
      if (take) begin
        full <= 1'b0;
      end else if (tx_valid_i && !full) begin
        full <= 1'b1;
        hold <= tx_data_i;
      end
    end
  end

  AST_NINTH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> sh[FRAME-1]); // R4
  AST_TAKE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(load_req)); // R10
  AST_KEEP_OUT_OF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ok && load_req && full) |=> full); // R7
endmodule

// File: rtl/nss_mode.sv
module nss_mode #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT_A = 8'h00,
  parameter logic [DATA_W-1:0] INIT_B = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              mode_done_o,
  output logic              mode_ok_o
);
  import nss_pkg::*;
  mode_state_e st;
  logic        first_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= MODE_FIRST;
      first_hit <= 1'b0;
    end else if (rx_done) begin
      case (st)
        MODE_FIRST: begin
          first_hit <= (rx_byte == INIT_A);
          st        <= MODE_SECOND;
        end
        MODE_SECOND: st <= (first_hit && rx_byte == INIT_B) ? MODE_ON : MODE_OFF;
        default: st <= st;
      endcase
    end
  end

  assign mode_done_o = (st == MODE_ON) || (st == MODE_OFF);
  assign mode_ok_o   = (st == MODE_ON);

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_done_o |=> mode_done_o && $stable(mode_ok_o)); // R7
endmodule

// File: rtl/ninec_serial_slave.sv
module ninec_serial_slave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] INIT_A = 8'h00,
  parameter logic [DATA_W-1:0] INIT_B = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              sel_n_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              mode_done_o,
  output logic              mode_ok_o
);
  logic [2:0]        pins_s;
  logic              sclk_s, sdi_s, sel_s;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_done, load_req, shift_req, deliver;

  nss_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sel_n_i, sdi_i, sclk_i}), .q_o(pins_s)
  );
  assign sclk_s = pins_s[0];
  assign sdi_s  = pins_s[1];
  assign sel_s  = ~pins_s[2];

  nss_frame_ctl #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sdi_s(sdi_s), .sel_s(sel_s),
    .rx_byte_o(rx_byte), .rx_done_o(rx_done),
    .load_req_o(load_req), .shift_req_o(shift_req)
  );

  nss_mode #(.DATA_W(DATA_W), .INIT_A(INIT_A), .INIT_B(INIT_B)) u_mode (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
    .mode_done_o(mode_done_o), .mode_ok_o(mode_ok_o)
  );

  nss_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .mode_ok(mode_ok_o),
    .load_req(load_req), .shift_req(shift_req),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .sdo_bit_o(sdo_o)
  );

  assign sdo_en_o = ~sel_n_i;
  assign deliver  = rx_done & mode_ok_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else if (deliver) begin
      rx_valid_o <= 1'b1;
      rx_data_o  <= rx_byte;
    end else if (rx_ready_i) begin
      rx_valid_o <= 1'b0;
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i && !rx_done) |=> rx_valid_o && $stable(rx_data_o)); // R9
  AST_NO_RX_OUT_OF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok_o |=> !$rose(rx_valid_o)); // R7
endmodule

// File: tb/tb_ninec_serial_slave.sv
module tb_ninec_serial_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, sel_n = 1'b1;
  logic sdo, sdo_en, rx_valid, rx_ready = 1'b0, tx_valid = 1'b0;
  logic tx_ready, mode_done, mode_ok;
  logic [7:0] rx_data, tx_data = '0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ninec_serial_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sel_n_i(sel_n),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .mode_done_o(mode_done), .mode_ok_o(mode_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdi = 1'b0; rx_ready = 1'b0; tx_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input logic [8:0] mosi, input int nbits, input bit keep,
                       output logic [8:0] miso);
    miso = '1;
    sel_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = mosi[i];
      repeat (7) @(negedge clk);
      miso[i] = sdo;
      if (i == 0) check("R8 en low-select", {31'd0, sdo_en}, 32'd1);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
    if (!keep) begin
      sel_n = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic push(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic take_rx();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic init_pair(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] m;
    frame({1'b0, a}, 9, 1'b0, m);
    check("R7 init miso ones", {23'd0, m}, 32'h1FF);
    check("R7 init not delivered", {31'd0, rx_valid}, 32'd0);
    frame({1'b1, b}, 9, 1'b0, m);
    check("R7 init not delivered", {31'd0, rx_valid}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [8:0] m;
    logic [7:0] pairs_a [4];
    logic [7:0] pairs_b [4];
    do_reset();
    check("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
    check("R1 tx_ready", {31'd0, tx_ready}, 32'd1);
    check("R1 mode_done", {31'd0, mode_done}, 32'd0);
    check("R1 mode_ok", {31'd0, mode_ok}, 32'd0);
    check("R8 en idle", {31'd0, sdo_en}, 32'd0);

    init_pair(8'h00, 8'hFF);
    check("R7 mode_done", {31'd0, mode_done}, 32'd1);
    check("R7 mode_ok", {31'd0, mode_ok}, 32'd1);

    // exhaustive byte sweep, ninth input bit varied (R3), tx byte = ~i (R4, R10)
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      b = 8'(i);
      push(~b);
      check("R10 ready low when full", {31'd0, tx_ready}, 32'd0);
      frame({b[0] ^ b[7], b}, 9, 1'b0, m);
      check("R2 byte reported", {31'd0, rx_valid}, 32'd1);
      check("R3 rx data", {24'd0, rx_data}, {24'd0, b});
      check("R4 tx data bits", {24'd0, m[7:0]}, {24'd0, ~b});
      check("R4 ninth bit high", {31'd0, m[8]}, 32'd1);
      check("R10 ready after start", {31'd0, tx_ready}, 32'd1);
      take_rx();
      check("R9 cleared by ready", {31'd0, rx_valid}, 32'd0);
    end

    // R5: nothing loaded
    frame(9'h033, 9, 1'b0, m);
    check("R5 idle byte", {23'd0, m}, 32'h1FF);
    take_rx();

    // R9: hold then overwrite
    frame(9'h03C, 9, 1'b0, m);
    repeat (20) @(negedge clk);
    check("R9 held valid", {31'd0, rx_valid}, 32'd1);
    check("R9 held data", {24'd0, rx_data}, 32'h3C);
    frame(9'h1A5, 9, 1'b0, m);
    check("R9 overwrite", {24'd0, rx_data}, 32'hA5);
    take_rx();

    // R2/R4: back-to-back frames with select held low
    push(8'h5A);
    frame(9'h011, 9, 1'b1, m);
    check("R4 first of pair", {23'd0, m}, 32'h15A);
    check("R2 first of pair", {24'd0, rx_data}, 32'h11);
    take_rx();
    frame(9'h122, 9, 1'b0, m);
    check("R5 second of pair", {23'd0, m}, 32'h1FF);
    check("R2 second of pair", {24'd0, rx_data}, 32'h22);
    check("R2 second valid", {31'd0, rx_valid}, 32'd1);
    take_rx();

    // R6: abort after four bits, then a clean frame
    frame(9'h0F7, 4, 1'b0, m);
    check("R6 no byte on abort", {31'd0, rx_valid}, 32'd0);
    check("R8 en after deselect", {31'd0, sdo_en}, 32'd0);
    frame(9'h0C3, 9, 1'b0, m);
    check("R6 restart bit 0", {24'd0, rx_data}, 32'hC3);
    take_rx();

    // R7: wrong initialization pairs
    pairs_a[0] = 8'h00; pairs_b[0] = 8'h12;
    pairs_a[1] = 8'h01; pairs_b[1] = 8'hFF;
    pairs_a[2] = 8'hFF; pairs_b[2] = 8'h00;
    pairs_a[3] = 8'h00; pairs_b[3] = 8'h7F;
    for (int p = 0; p < 4; p++) begin
      do_reset();
      init_pair(pairs_a[p], pairs_b[p]);
      check("R7 bad pair done", {31'd0, mode_done}, 32'd1);
      check("R7 bad pair ok", {31'd0, mode_ok}, 32'd0);
      push(8'h42);
      frame(9'h077, 9, 1'b0, m);
      check("R7 no delivery", {31'd0, rx_valid}, 32'd0);
      check("R7 ones out", {23'd0, m}, 32'h1FF);
      check("R7 buffer kept", {31'd0, tx_ready}, 32'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule